// File: doc/BRIEF.md
# Packed Byte Permute and Align Unit

This unit works on two 128-bit operands, each seen as sixteen bytes, and produces one 128-bit result per accepted operation. It has two operations, picked per operation by a one-bit select. The first is a data-driven byte permute. Each control byte in operand B picks one byte of operand A for the matching output position, or forces that position to zero.

The second operation is a byte-granular funnel alignment. Operand A is placed above operand B to form a 32-byte value. That value is shifted right by an 8-bit immediate count of whole bytes, and the low sixteen bytes are kept. Counts of 32 and above leave nothing of the concatenation in the window.

Byte 0 sits in bits [7:0] of each bus and byte 15 in bits [127:120]. A new operation may be presented on every cycle. Its result and a valid flag appear exactly one cycle after it is accepted.

Top module: `byte_perm_align`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0.
- R2: `out_valid` is 1 in the cycle after `in_valid` was 1, and 0 in the cycle after `in_valid` was 0. Every accepted operation yields exactly one result, in order.
- R3: With `op_sel` = 0 (permute), output byte i equals the byte of A whose index is bits [3:0] of control byte B[i]. Bits [6:4] of the control byte and the immediate have no effect.
- R4: With `op_sel` = 0, if bit 7 of control byte B[i] is 1, output byte i is 0x00 whatever the index bits hold.
- R5: With `op_sel` = 1 (align) and a count n from 1 to 15, output byte i equals byte (i+n) of the 32-byte value {A,B}, where bytes 0..15 of that value are B and bytes 16..31 are A.
- R6: With `op_sel` = 1, a count of 0 returns B unchanged and a count of 16 returns A unchanged.
- R7: With `op_sel` = 1 and a count n from 17 to 31, output byte i is A byte (i+n-16) while that index is below 16, and the top n-16 output bytes are 0x00.
- R8: With `op_sel` = 1, any count of 32 or more (up to 255) gives an all-zero result.
- R9: In a cycle where `in_valid` is 0, `result` keeps the value it held, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| op_sel | input | 1 | 0 = byte permute, 1 = funnel align |
| src_a | input | 128 | Operand A: permute table, or upper half of the align concatenation |
| src_b | input | 128 | Operand B: permute control bytes, or lower half of the align concatenation |
| shift_imm | input | 8 | Align byte count; not used by the permute |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 128 | Registered result |

## Verification
The two operations share one result register, so a permute and an align can follow each other on consecutive cycles. Each result must then come from its own operation's operands, with no leakage from the other path or from the previous entry. The bench provokes this with a long run of back-to-back operations that switch mode at random while `in_valid` stays high. Every expected result is queued in issue order, and the monitor matches each one against the output one cycle later.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = 16;
  localparam int unsigned CNT_W   = 8;

  typedef enum logic {
    OP_PERMUTE = 1'b0,
    OP_ALIGN   = 1'b1
  } bpa_op_e;
endpackage

// File: rtl/bpa_permute.sv
// Byte permute: every output lane indexes into the table operand.
module bpa_permute #(
  parameter int unsigned NB = 16,
  parameter int unsigned BW = 8
) (
  input  logic [NB*BW-1:0] table_i,
  input  logic [NB*BW-1:0] ctrl_i,
  output logic [NB*BW-1:0] perm_o
);
  localparam int unsigned IDX_W = $clog2(NB);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0]    ctrl_byte;
    logic [IDX_W-1:0] idx;
    assign ctrl_byte = ctrl_i[g*BW +: BW];
    // index is the control byte modulo the lane count
    assign idx = IDX_W'(ctrl_byte % BW'(NB));

    always_comb begin
      if (ctrl_byte[BW-1]) begin
        perm_o[g*BW +: BW] = '0;
      end else begin
        perm_o[g*BW +: BW] = table_i[int'(idx)*BW +: BW];
      end
    end
  end
endmodule

// File: rtl/bpa_align.sv
// Funnel align: window of NB bytes taken out of {hi, lo} at a byte offset.
module bpa_align #(
  parameter int unsigned NB = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned CW = 8
) (
  input  logic [NB*BW-1:0] hi_i,
  input  logic [NB*BW-1:0] lo_i,
  input  logic [CW-1:0]    cnt_i,
  output logic [NB*BW-1:0] align_o
);
  localparam int unsigned IDX_W = $clog2(NB);
  localparam int unsigned POS_W = CW + 1;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] sub;
    assign pos = {1'b0, cnt_i} + POS_W'(g);
    assign sub = pos[IDX_W-1:0];

    always_comb begin
      // upper bits of pos select which half, or nothing
      if (pos[POS_W-1:IDX_W] == '0) begin
        align_o[g*BW +: BW] = lo_i[int'(sub)*BW +: BW];
      end else if (pos[POS_W-1:IDX_W] == (POS_W-IDX_W)'(1)) begin
        align_o[g*BW +: BW] = hi_i[int'(sub)*BW +: BW];
      end else begin
        align_o[g*BW +: BW] = '0;
      end
    end
  end
endmodule

// File: rtl/byte_perm_align.sv
module byte_perm_align
  import bpa_pkg::*;
#(
  parameter int unsigned NB = N_BYTES,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op_sel,
  input  logic [NB*BW-1:0] src_a,
  input  logic [NB*BW-1:0] src_b,
  input  logic [CW-1:0]    shift_imm,
  output logic             out_valid,
  output logic [NB*BW-1:0] result
);
  localparam int unsigned DW = NB * BW;

  logic [DW-1:0] perm_res;
  logic [DW-1:0] align_res;
  logic [DW-1:0] result_d;
  logic [DW-1:0] result_q;
  logic          valid_q;

  bpa_permute #(.NB(NB), .BW(BW)) u_permute (
    .table_i (src_a),
    .ctrl_i  (src_b),
    .perm_o  (perm_res)
  );

  bpa_align #(.NB(NB), .BW(BW), .CW(CW)) u_align (
    .hi_i    (src_a),
    .lo_i    (src_b),
    .cnt_i   (shift_imm),
    .align_o (align_res)
  );

  always_comb begin
    unique case (bpa_op_e'(op_sel))
      OP_ALIGN: result_d = align_res;
      default:  result_d = perm_res;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= result_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker #(
  parameter int unsigned NB = 16,
  parameter int unsigned BW = 8,
  parameter int unsigned CW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             op_sel,
  input logic [NB*BW-1:0] src_a,
  input logic [NB*BW-1:0] src_b,
  input logic [CW-1:0]    shift_imm,
  input logic             out_valid,
  input logic [NB*BW-1:0] result
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r4_perm_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sel && src_b[BW-1]) |=> (result[BW-1:0] == '0));

  a_r6_align_zero_gives_b: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel && shift_imm == '0) |=> (result == $past(src_b)));

  a_r6_align_full_gives_a: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel && shift_imm == CW'(NB)) |=> (result == $past(src_a)));

  a_r7_align_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel && shift_imm == CW'(2*NB-1)) |=> (result[NB*BW-1:BW] == '0));

  a_r8_align_far_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel && shift_imm >= CW'(2*NB)) |=> (result == '0));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
endmodule

bind byte_perm_align bpa_checker #(.NB(NB), .BW(BW), .CW(CW)) u_bpa_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .src_a     (src_a),
  .src_b     (src_b),
  .shift_imm (shift_imm),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/test_byte_perm_align.sv
module test_byte_perm_align;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         op_sel;
  logic [127:0] src_a;
  logic [127:0] src_b;
  logic [7:0]   shift_imm;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [127:0] val;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  byte_perm_align i_byte_perm_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .shift_imm (shift_imm),
    .out_valid (out_valid),
    .result    (result)
  );

  function automatic logic [127:0] model(logic op, logic [127:0] a, logic [127:0] b, logic [7:0] n);
    logic [127:0] r;
    logic [255:0] cat;
    r = '0;
    if (!op) begin
      for (int i = 0; i < 16; i++) begin
        logic [7:0] c;
        c = b[i*8 +: 8];
        if (c[7] == 1'b0) r[i*8 +: 8] = a[c[3:0]*8 +: 8];
      end
    end else if (n < 8'd32) begin
      cat = {a, b};
      cat = cat >> (int'(n) * 8);
      r = cat[127:0];
    end
    return r;
  endfunction

  function automatic logic [127:0] ramp(int base);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(base + i);
    return v;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic op, logic [127:0] a, logic [127:0] b, logic [7:0] n, string tag);
    exp_t e;
    @(negedge clk);
    in_valid  = 1'b1;
    op_sel    = op;
    src_a     = a;
    src_b     = b;
    shift_imm = n;
    e.val = model(op, a, b, n);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: samples shortly after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 actual=out_valid 1 expected=out_valid 0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, result, e.val);
        end
      end else if (sb.size() != 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=out_valid 0 expected=out_valid 1");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] a0, ctl, last;
    rst_n = 1'b0; in_valid = 1'b1; op_sel = 1'b0;
    src_a = '0; src_b = '0; shift_imm = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 actual=%b expected=0", out_valid); end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #2;
    checks++;
    if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 actual=%b expected=0", out_valid); end

    a0 = ramp(1);
    // R3 / R4: mixed indices, top-bit zeroing, index bits above 3
    ctl = {8'h00, 8'h08, 8'h01, 8'h04, 8'h0A, 8'h05, 8'h05, 8'h0C,
           8'h13, 8'h06, 8'h0C, 8'h18, 8'h03, 8'h04, 8'h80, 8'h04};
    issue(1'b0, a0, ctl, 8'd40, "R4");
    issue(1'b0, a0, {16{8'h7F}}, 8'd0, "R3");
    issue(1'b0, a0, {16{8'hFF}}, 8'd3, "R4");
    issue(1'b0, a0, {8'h30, 8'h41, 8'h52, 8'h63, 8'h74, 8'h05, 8'h16, 8'h27,
                     8'h38, 8'h49, 8'h5A, 8'h6B, 8'h7C, 8'h0D, 8'h1E, 8'h2F}, 8'd9, "R3");
    // align
    issue(1'b1, a0, ramp(8'h40), 8'd0,  "R6");
    issue(1'b1, a0, ramp(8'h40), 8'd16, "R6");
    issue(1'b1, a0, ramp(8'h40), 8'd1,  "R5");
    issue(1'b1, a0, ramp(8'h40), 8'd7,  "R5");
    issue(1'b1, a0, ramp(8'h40), 8'd15, "R5");
    issue(1'b1, a0, ramp(8'h40), 8'd17, "R7");
    issue(1'b1, a0, ramp(8'h40), 8'd31, "R7");
    issue(1'b1, a0, ramp(8'h40), 8'd32, "R8");
    issue(1'b1, a0, ramp(8'h40), 8'd33, "R8");
    issue(1'b1, a0, ramp(8'h40), 8'd255, "R8");
    idle();
    idle();

    // back-to-back mixed operations
    for (int k = 0; k < 40; k++) begin
      logic op;
      op = 1'($urandom);
      issue(op, {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom},
                8'($urandom % 40), op ? "R5" : "R3");
    end
    last = sb[sb.size()-1].val;
    idle();
    // R9: idle cycles with changing inputs must not disturb the result
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      op_sel = 1'(k); src_a = ~src_a; src_b = ramp(k); shift_imm = 8'(k);
      @(posedge clk); #2;
      check("R9", result, last);
    end
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule